// File: doc/BRIEF.md
# Dibit PN Spreading Transmitter with Scrambler

This block turns a serial data stream into a spread-spectrum chip stream. Data bits arrive one at a time over a ready/valid handshake and are grouped into pairs. Each pair selects one of four 32-chip spreading codewords that the host loads through a small write port. The chosen codeword is sent one chip per chip-clock enable, starting with its most significant bit. Each chip is XORed with the output of a free-running 11-stage maximal-length scrambler (period 2047) before it leaves the block, which whitens the spectrum.

The output is a single chip line plus an output enable, which together model a tri-state driver. The enable is low whenever the block is out of transmit mode, and also during chip slots in which no complete bit pair is available. In those slots the block sends nothing rather than repeating an old codeword. The scrambler steps only on chips that are actually sent, so it keeps its place across gaps and mode changes.

Top module: `dibit_spread_tx`

## Requirements
- R1: After reset, chip_oe and chip_out are 0, all four codeword slots hold zero, and the scrambler state is all ones (11'h7FF).
- R2: A write (cw_we high) stores cw_data in slot cw_sel at that clock edge. A codeword starts from the slot contents held before that edge, so a write to a slot in the same cycle a codeword from that slot starts does not change that codeword. Later codewords use the new contents.
- R3: in_ready is high exactly when tx_mode is high and fewer than two bits are held. The first accepted bit of a pair is the MSB of the slot index (pair "1 then 0" selects slot 2).
- R4: On each edge where chip_en and tx_mode are both high, a codeword in progress sends its next chip. Chips go from codeword bit 31 down to bit 0, 32 chips in all. When a full pair is held at a codeword boundary, the next codeword starts on that same edge with no gap.
- R5: Each sent chip equals codeword chip XOR scrambler bit s[10]. After each sent chip the scrambler shifts s <= {s[9:0], s[10]^s[8]} (polynomial x^11+x^9+1).
- R6: A chip slot at a codeword boundary with fewer than two bits held drives chip_oe=0 and chip_out=0, and leaves the scrambler unchanged.
- R7: When tx_mode is low, chip_oe and chip_out are 0 after the next edge. Any codeword in progress is abandoned, no bits are accepted, and held bits and scrambler state are kept.
- R8: While tx_mode is high, an edge with chip_en low leaves chip_out and chip_oe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | 1 | Serial data bit |
| in_valid | input | 1 | in_bit is valid |
| in_ready | output | 1 | Block accepts in_bit this cycle |
| cw_we | input | 1 | Codeword slot write strobe |
| cw_sel | input | 2 | Codeword slot to write |
| cw_data | input | 32 | Codeword contents, bit 31 sent first |
| chip_en | input | 1 | Chip-clock enable |
| tx_mode | input | 1 | Transmit mode; low forces the output idle |
| chip_out | output | 1 | Scrambled chip, 0 when idle |
| chip_oe | output | 1 | Output driver enable |

## Verification
Two pairs of functions can fall on the same edge. The first is a host write to a slot and the start of a codeword from that slot. The bench provokes it by holding a full pair for slot 2 and raising cw_we for slot 2 together with the chip_en that starts the codeword. All 32 chips must match the old contents, and the next codeword from slot 2 must match the new ones. The second is a tx_mode fall in the middle of a codeword while one bit of the next pair is held. After the fall the output must be idle and no bits may be taken. When transmission resumes, the held bit must form the MSB of the next index and the scrambler must continue from where it stopped.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int SPR_NUM_CW   = 4;
    localparam int SPR_CW_BITS  = 32;
    localparam int SPR_LFSR_W   = 11;
    localparam int SPR_TAP_LO   = 8;

    typedef enum logic {
        PH_GAP  = 1'b0,
        PH_SEND = 1'b1
    } phase_e;
endpackage

// File: rtl/spr_codebook.sv
module spr_codebook #(
    parameter int NUM_CW  = spr_pkg::SPR_NUM_CW,
    parameter int CW_BITS = spr_pkg::SPR_CW_BITS,
    localparam int SEL_W  = $clog2(NUM_CW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [CW_BITS-1:0] wr_word,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [CW_BITS-1:0] rd_word
);
    logic [NUM_CW-1:0][CW_BITS-1:0] slots_d, slots_q;

    always_comb begin
        slots_d = slots_q;
        if (wr_en) begin
            slots_d[wr_sel] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assign rd_word = slots_q[rd_sel];

    // R2: slot contents move only on a write strobe
    assert_slots_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slots_q));
endmodule

// File: rtl/spr_scrambler.sv
module spr_scrambler #(
    parameter int          W      = spr_pkg::SPR_LFSR_W,
    parameter int          TAP_LO = spr_pkg::SPR_TAP_LO,
    parameter logic [W-1:0] SEED  = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic bit_out
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP_LO]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign bit_out = state_q[W-1];

    // R5: a maximal-length register never reaches the all-zero lockup state
    assert_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R6: no step, no movement
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));
endmodule

// File: rtl/dibit_spread_tx.sv
module dibit_spread_tx #(
    parameter int NUM_CW  = spr_pkg::SPR_NUM_CW,
    parameter int CW_BITS = spr_pkg::SPR_CW_BITS,
    parameter int LFSR_W  = spr_pkg::SPR_LFSR_W,
    localparam int SYM_BITS = $clog2(NUM_CW),
    localparam int NB_W     = $clog2(SYM_BITS + 1),
    localparam int CNT_W    = $clog2(CW_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_bit,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                cw_we,
    input  logic [SYM_BITS-1:0] cw_sel,
    input  logic [CW_BITS-1:0]  cw_data,
    input  logic                chip_en,
    input  logic                tx_mode,
    output logic                chip_out,
    output logic                chip_oe
);
    import spr_pkg::*;

    typedef struct packed {
        logic [SYM_BITS-1:0] pair;
        logic [NB_W-1:0]     nbits;
        phase_e              phase;
        logic [CNT_W-1:0]    left;
        logic [CW_BITS-1:0]  shreg;
        logic                chip;
        logic                oe;
    } tx_state_t;

    tx_state_t d, q;

    logic [CW_BITS-1:0] cb_word;
    logic               scr_bit;
    logic               scr_step;
    logic               send;
    logic               send_bit;

    spr_codebook #(.NUM_CW(NUM_CW), .CW_BITS(CW_BITS)) u_codebook (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_we),
        .wr_sel  (cw_sel),
        .wr_word (cw_data),
        .rd_sel  (q.pair),
        .rd_word (cb_word)
    );

    spr_scrambler #(.W(LFSR_W)) u_scrambler (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (scr_step),
        .bit_out (scr_bit)
    );

    assign in_ready = tx_mode && (q.nbits < NB_W'(SYM_BITS));

    always_comb begin
        d        = q;
        send     = 1'b0;
        send_bit = 1'b0;
        scr_step = 1'b0;

        // bit collection: first bit ends up as index MSB
        if (in_valid && in_ready) begin
            d.pair  = SYM_BITS'({q.pair, in_bit});
            d.nbits = q.nbits + NB_W'(1);
        end

        if (!tx_mode) begin
            d.phase = PH_GAP;
            d.oe    = 1'b0;
            d.chip  = 1'b0;
        end else if (chip_en) begin
            if (q.phase == PH_SEND) begin
                send     = 1'b1;
                send_bit = q.shreg[CW_BITS-1];
                d.shreg  = q.shreg << 1;
                d.left   = q.left - CNT_W'(1);
                if (q.left == CNT_W'(1)) begin
                    d.phase = PH_GAP;
                end
            end else if (q.nbits == NB_W'(SYM_BITS)) begin
                send     = 1'b1;
                send_bit = cb_word[CW_BITS-1];
                d.shreg  = cb_word << 1;
                d.left   = CNT_W'(CW_BITS - 1);
                d.phase  = PH_SEND;
                d.nbits  = '0;
            end else begin
                d.oe   = 1'b0;
                d.chip = 1'b0;
            end
            if (send) begin
                d.chip   = send_bit ^ scr_bit;
                d.oe     = 1'b1;
                scr_step = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_GAP;
        end else begin
            q <= d;
        end
    end

    assign chip_out = q.chip;
    assign chip_oe  = q.oe;

    // R7: leaving transmit mode floats the driver by the next edge
    assert_oe_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |=> !chip_oe);

    // R6: an undriven line carries a zero
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_oe |-> !chip_out);

    // R8: no chip-clock enable, no output change
    assert_chip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && !chip_en) |=> $stable({chip_oe, chip_out}));

    // R3: no bit is taken outside transmit mode
    assert_no_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mode && !chip_en) |=> $stable(q.nbits));
endmodule

// File: tb/sim_dibit_spread_tx.sv
`timescale 1ns/1ps
module sim_dibit_spread_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_bit = 1'b0, in_valid = 1'b0, in_ready;
    logic        cw_we = 1'b0;
    logic [1:0]  cw_sel = '0;
    logic [31:0] cw_data = '0;
    logic        chip_en = 1'b0, tx_mode = 1'b0;
    logic        chip_out, chip_oe;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_cw [4];
    logic [10:0] m_s = 11'h7FF;

    // each entry: {first bit, second bit, expected slot}
    localparam logic [3:0] VEC [8] = '{
        4'b00_00, 4'b11_11, 4'b01_01, 4'b10_10,
        4'b11_11, 4'b00_00, 4'b10_10, 4'b01_01
    };

    always #2.5 clk = ~clk;

    dibit_spread_tx u0 (
        .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
        .in_ready(in_ready), .cw_we(cw_we), .cw_sel(cw_sel), .cw_data(cw_data),
        .chip_en(chip_en), .tx_mode(tx_mode), .chip_out(chip_out), .chip_oe(chip_oe)
    );

    function automatic logic [10:0] lstep(input logic [10:0] s);
        return {s[9:0], s[10] ^ s[8]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cw(input logic [1:0] sel, input logic [31:0] val);
        cw_we = 1'b1; cw_sel = sel; cw_data = val;
        @(posedge clk); @(negedge clk);
        cw_we = 1'b0;
        m_cw[sel] = val;
    endtask

    task automatic push_bit(input logic b);
        in_valid = 1'b1; in_bit = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tick_check(input logic [31:0] w, input int k, input string req);
        logic e;
        chip_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chip_en = 1'b0;
        e = w[31-k] ^ m_s[10];
        m_s = lstep(m_s);
        chk(req, {30'd0, chip_oe, chip_out}, {30'd0, 1'b1, e});
    endtask

    task automatic tick_idle(input string req);
        chip_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chip_en = 1'b0;
        chk(req, {30'd0, chip_oe, chip_out}, 32'd0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] hold;
        logic [31:0] old2;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {29'd0, chip_oe, chip_out, in_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {30'd0, chip_oe, chip_out}, 32'd0);

        write_cw(2'd0, 32'hA5C3_0F96);
        write_cw(2'd1, 32'h1234_5678);
        write_cw(2'd2, 32'hF0F0_3C3C);
        write_cw(2'd3, 32'h8000_0001);

        // R6: transmit mode, nothing held
        tx_mode = 1'b1;
        @(negedge clk);
        chk("R3 ready with no bits", {31'd0, in_ready}, 32'd1);
        tick_idle("R6 idle no bits");
        push_bit(1'b1);
        tick_idle("R6 idle one bit");
        chk("R3 ready with one bit", {31'd0, in_ready}, 32'd1);
        push_bit(1'b0);
        chk("R3 ready low with pair", {31'd0, in_ready}, 32'd0);
        // pair 1,0 -> slot 2; scrambler still at seed (R6)
        for (int k = 0; k < 32; k++) begin
            tick_check(m_cw[2], k, "R3 R6 slot 2 from seed");
            if (k == 3) begin
                hold = {chip_oe, chip_out};
                repeat (3) @(negedge clk);
                chk("R8 hold without chip_en", {30'd0, chip_oe, chip_out}, {30'd0, hold});
            end
        end

        // R4/R5: table walk, back-to-back codewords
        push_bit(VEC[0][3]); push_bit(VEC[0][2]);
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 32; k++) begin
                if (k == 7 && i < 7) begin
                    push_bit(VEC[i+1][3]); push_bit(VEC[i+1][2]);
                    chk("R3 ready low while pair waits", {31'd0, in_ready}, 32'd0);
                end
                tick_check(m_cw[VEC[i][1:0]], k, "R4 R5 table codeword");
            end
        end
        tick_idle("R6 boundary without pair");

        // R2: write to slot 2 on the same edge its codeword starts
        old2 = m_cw[2];
        push_bit(1'b1); push_bit(1'b0);
        cw_we = 1'b1; cw_sel = 2'd2; cw_data = 32'h0F0F_AAAA; chip_en = 1'b1;
        @(posedge clk); @(negedge clk);
        cw_we = 1'b0; chip_en = 1'b0;
        chk("R2 collision first chip", {30'd0, chip_oe, chip_out}, {30'd0, 1'b1, old2[31] ^ m_s[10]});
        m_s = lstep(m_s);
        m_cw[2] = 32'h0F0F_AAAA;
        for (int k = 1; k < 32; k++) tick_check(old2, k, "R2 collision uses old word");
        push_bit(1'b1); push_bit(1'b0);
        for (int k = 0; k < 32; k++) tick_check(m_cw[2], k, "R2 new word after write");

        // R7: tx_mode falls mid-codeword with one bit held
        push_bit(1'b0); push_bit(1'b1);
        for (int k = 0; k < 10; k++) tick_check(m_cw[1], k, "R7 before drop");
        push_bit(1'b1);
        tx_mode = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 output idle after drop", {30'd0, chip_oe, chip_out}, 32'd0);
        chk("R7 ready low", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1; in_bit = 1'b0; chip_en = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0; chip_en = 1'b0;
        chk("R7 no chips while off", {30'd0, chip_oe, chip_out}, 32'd0);
        tx_mode = 1'b1;
        @(negedge clk);
        push_bit(1'b1);
        // held 1 is MSB -> slot 3, fresh start, scrambler continues
        for (int k = 0; k < 32; k++) tick_check(m_cw[3], k, "R7 resume slot 3");

        summary();
        $finish;
    end
endmodule